// File: doc/BRIEF.md
# Backlight PWM Generator with Programmable Dividers

This block drives a display backlight with a pulse-width-modulated signal. The PWM period is built from the reference clock in two stages: an 8-bit pre-divider F, followed by a binary stage of 2^Pn steps. One period therefore lasts F × 2^Pn reference cycles. The duty cycle comes from a 16-bit brightness value. That value is read from its most significant end, so that only the top Pn bits count, whatever the bit count currently selected.

Software sets the block up through a byte-wide register port with separate write and read addresses. A static strap input selects how brightness is held. In wide mode, brightness is two bytes, high and low. In narrow mode, only the high byte is used. Divider, bit-count and brightness changes are held back until the running period ends. A new setting therefore never shortens or stretches a period.

Top module: `bl_pwm_gen`

## Requirements
- R1: After synchronous reset, `pwm_out` is 0, the mode, divider and brightness registers read 0, and both counters restart from zero.
- R2: The register map is as follows. Address 0 is mode: bit 0 is the backlight enable and bit 1 is the frequency-set enable. Address 1 is the pre-divider F. Address 2 is the bit count. Address 3 is brightness high byte and address 4 is brightness low byte. Other addresses read 0. `rd_data` is registered, so it shows the addressed register one cycle after `rd_addr` is applied. Address 2 reads back the Pn in force in bits 4:0, with bits 7:5 reading 0.
- R3: With frequency-set enabled, one PWM period lasts F × 2^Pn clock cycles. An F of 0 is treated as 1.
- R4: The bit count uses only bits 4:0 of its write data. That 5-bit value is limited to the range CAP_MIN..CAP_MAX, and a value outside it takes the nearest limit.
- R5: The duty value is the top Pn bits of the 16-bit brightness value, and the lower 16−Pn bits are discarded. The output is high for duty × F cycles of each period, starting at the period's first cycle.
- R6: With `wide_bright` at 0, the brightness value is {high byte, 8'h00}, and the low-byte register has no effect on the output.
- R7: A duty value of all zeros keeps the output low. A duty value of all ones in the Pn assigned bits keeps it continuously high.
- R8: With frequency-set disabled, the period uses DEF_F and DEF_PN, and the divider and bit-count registers have no effect.
- R9: New F, Pn and brightness values take effect only at the end of the running period.
- R10: While the backlight enable is 0, `pwm_out` is low one cycle later and the counters are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_bright | input | 1 | Strap: 1 = two-byte brightness, 0 = high byte only |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The hardest case to create from the ports is a brightness change that lands in the middle of a running period. The bench reaches it by locking onto a rising edge of the output with a short duty. It then rewrites the high byte to full brightness 20 cycles into the period. It checks that the output stays low for the rest of that period and only goes high at the next period's first cycle. The other settings are checked by counting high cycles over a window of two whole periods, which works at any phase, and by timing the gap between rising edges.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int BR_W   = 16;
  localparam int F_W    = 8;
  localparam int PN_W   = 5;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_FDIV = 3'd1;
  localparam logic [ADDR_W-1:0] A_BITS = 3'd2;
  localparam logic [ADDR_W-1:0] A_BMSB = 3'd3;
  localparam logic [ADDR_W-1:0] A_BLSB = 3'd4;

  function automatic logic [PN_W-1:0] limit_pn(input logic [PN_W-1:0] raw,
                                               input int lo, input int hi);
    if (int'(raw) < lo)      return PN_W'(lo);
    else if (int'(raw) > hi) return PN_W'(hi);
    else                     return raw;
  endfunction
endpackage

// File: rtl/bl_regs.sv
module bl_regs
  import bl_pwm_pkg::*;
#(
  parameter int CAP_MIN = 1,
  parameter int CAP_MAX = 16,
  parameter int DEF_F   = 4,
  parameter int DEF_PN  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_bright,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              en,
  output logic [F_W-1:0]    tgt_f,
  output logic [PN_W-1:0]   tgt_pn,
  output logic [BR_W-1:0]   tgt_duty,
  output logic              tgt_full
);
  logic             fset;
  logic [F_W-1:0]   fdiv;
  logic [PN_W-1:0]  pn_lim;
  logic [REG_W-1:0] b_hi, b_lo;
  logic [BR_W-1:0]  bright;
  logic [BR_W:0]    mask;
  logic [PN_W-1:0]  shamt;

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      fset   <= 1'b0;
      fdiv   <= '0;
      pn_lim <= limit_pn('0, CAP_MIN, CAP_MAX);
      b_hi   <= '0;
      b_lo   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE: begin en <= wr_data[0]; fset <= wr_data[1]; end
        A_FDIV: fdiv   <= wr_data[F_W-1:0];
        A_BITS: pn_lim <= limit_pn(wr_data[PN_W-1:0], CAP_MIN, CAP_MAX);
        A_BMSB: b_hi   <= wr_data;
        A_BLSB: b_lo   <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        A_MODE:  rd_data <= {{(REG_W-2){1'b0}}, fset, en};
        A_FDIV:  rd_data <= REG_W'(fdiv);
        A_BITS:  rd_data <= REG_W'(pn_lim);
        A_BMSB:  rd_data <= b_hi;
        A_BLSB:  rd_data <= b_lo;
        default: rd_data <= '0;
      endcase
    end
  end

  always_comb begin
    if (fset) begin
      tgt_f  = (fdiv == '0) ? F_W'(1) : fdiv;
      tgt_pn = pn_lim;
    end else begin
      tgt_f  = F_W'(DEF_F);
      tgt_pn = PN_W'(DEF_PN);
    end
    bright   = wide_bright ? {b_hi, b_lo} : {b_hi, {REG_W{1'b0}}};
    shamt    = PN_W'(BR_W) - tgt_pn;
    mask     = ({{BR_W{1'b0}}, 1'b1} << tgt_pn) - 1'b1;
    tgt_duty = bright >> shamt;
    tgt_full = (tgt_duty == mask[BR_W-1:0]);
  end
endmodule

// File: rtl/bl_prescale.sv
module bl_prescale #(
  parameter int F_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic [F_W-1:0] div,
  output logic           tick
);
  logic [F_W-1:0] cnt;

  assign tick = !clr && (cnt == div - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bl_period.sv
module bl_period #(
  parameter int CNT_W = 16,
  parameter int PN_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [PN_W-1:0]  pn,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W:0] last;

  always_comb begin
    last = ({{CNT_W{1'b0}}, 1'b1} << pn) - 1'b1;
    wrap = tick && (cnt == last[CNT_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (wrap)  cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen
  import bl_pwm_pkg::*;
#(
  parameter int CAP_MIN = 1,
  parameter int CAP_MAX = 16,
  parameter int DEF_F   = 4,
  parameter int DEF_PN  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_bright,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              pwm_out
);
  logic            en_q;
  logic [F_W-1:0]  tgt_f, act_f;
  logic [PN_W-1:0] tgt_pn, act_pn;
  logic [BR_W-1:0] tgt_duty, act_duty, per_cnt;
  logic            tgt_full, act_full;
  logic            tick, wrap, load;

  bl_regs #(.CAP_MIN(CAP_MIN), .CAP_MAX(CAP_MAX), .DEF_F(DEF_F), .DEF_PN(DEF_PN)) u_regs (
    .clk(clk), .rst(rst), .wide_bright(wide_bright),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .en(en_q), .tgt_f(tgt_f), .tgt_pn(tgt_pn),
    .tgt_duty(tgt_duty), .tgt_full(tgt_full)
  );

  bl_prescale #(.F_W(F_W)) u_pre (
    .clk(clk), .rst(rst), .clr(!en_q), .div(act_f), .tick(tick)
  );

  bl_period #(.CNT_W(BR_W), .PN_W(PN_W)) u_per (
    .clk(clk), .rst(rst), .clr(!en_q), .tick(tick), .pn(act_pn),
    .cnt(per_cnt), .wrap(wrap)
  );

  // shadow settings: refreshed while idle or at the end of a period
  assign load = !en_q || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_f    <= F_W'(DEF_F);
      act_pn   <= PN_W'(DEF_PN);
      act_duty <= '0;
      act_full <= 1'b0;
    end else if (load) begin
      act_f    <= tgt_f;
      act_pn   <= tgt_pn;
      act_duty <= tgt_duty;
      act_full <= tgt_full;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= en_q && (act_full || (per_cnt < act_duty));
  end
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk
  import bl_pwm_pkg::*;
#(
  parameter int CAP_MIN = 1,
  parameter int CAP_MAX = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            pwm_out,
  input logic            en_q,
  input logic            wrap,
  input logic [F_W-1:0]  act_f,
  input logic [PN_W-1:0] act_pn,
  input logic [BR_W-1:0] act_duty,
  input logic            act_full
);
  // R1
  p_rst_low_r1: assert property (@(posedge clk) rst |=> !pwm_out);
  // R10
  p_off_low_r10: assert property (@(posedge clk) disable iff (rst) !en_q |=> !pwm_out);
  // R3
  p_f_nonzero_r3: assert property (@(posedge clk) disable iff (rst) act_f != '0);
  // R4
  p_pn_range_r4: assert property (@(posedge clk) disable iff (rst)
    en_q |-> (int'(act_pn) >= CAP_MIN && int'(act_pn) <= CAP_MAX));
  // R9
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (en_q && !wrap) |=> ($stable(act_f) && $stable(act_pn) && $stable(act_duty) && $stable(act_full)));
  // R7
  p_zero_low_r7: assert property (@(posedge clk) disable iff (rst)
    (act_duty == '0 && !act_full) |=> !pwm_out);
  // R7
  p_full_high_r7: assert property (@(posedge clk) disable iff (rst)
    (en_q && act_full) |=> pwm_out);
endmodule

bind bl_pwm_gen bl_pwm_chk #(.CAP_MIN(CAP_MIN), .CAP_MAX(CAP_MAX)) u_chk (
  .clk(clk), .rst(rst), .pwm_out(pwm_out), .en_q(en_q), .wrap(wrap),
  .act_f(act_f), .act_pn(act_pn), .act_duty(act_duty), .act_full(act_full)
);

// File: tb/sim_bl_pwm_gen.sv
module sim_bl_pwm_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wide_bright = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       pwm_out;

  int checks = 0;
  int fails  = 0;
  int cur_p  = 64;
  int cyc    = 0;
  bit busy   = 1'b0;

  string q_tag[$];
  int    q_high[$];
  int    q_per[$];

  always #10 clk = ~clk;  // 50 MHz

  bl_pwm_gen u0 (
    .clk(clk), .rst(rst), .wide_bright(wide_bright),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  // driver: wait for the new setting to settle, queue the expectation
  task automatic expect_pwm(input string tag, input int high, input int per);
    repeat (cur_p + per + 8) @(negedge clk);
    cur_p = per;
    q_tag.push_back(tag); q_high.push_back(high); q_per.push_back(per);
    busy = 1'b1;
    wait (!busy);
  endtask

  // monitor: pop one expectation and measure it at the output
  initial begin
    forever begin
      wait (busy);
      begin
        string tag = q_tag.pop_front();
        int eh = q_high.pop_front();
        int ep = q_per.pop_front();
        int hc = 0;
        for (int i = 0; i < 2 * ep; i++) begin
          @(negedge clk);
          if (pwm_out) hc++;
        end
        check({tag, " high cycles"}, hc, 2 * eh);
        if (eh > 0 && eh < ep) begin
          int gap = 0;
          bit prev = 1'b1;
          @(negedge clk); prev = pwm_out;
          while (!(prev == 1'b0 && pwm_out == 1'b1)) begin
            prev = pwm_out; @(negedge clk);
          end
          prev = pwm_out;
          @(negedge clk); gap = 1;
          while (!(prev == 1'b0 && pwm_out == 1'b1)) begin
            prev = pwm_out; @(negedge clk); gap++;
          end
          check({tag, " period"}, gap, ep);
        end
      end
      busy = 1'b0;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pwm_out after reset", int'(pwm_out), 0);
    rd(3'd0, v); check("R1 mode reg", v, 0);
    rd(3'd3, v); check("R1 bright hi", v, 0);
    rd(3'd2, v); check("R4 bit count clamped to min", v, 1);

    // R2 / R4 readback and clamp (backlight off)
    wr(3'd2, 8'h3F); rd(3'd2, v); check("R4 clamp to max", v, 16);
    wr(3'd2, 8'hE5); rd(3'd2, v); check("R4 upper bits ignored", v, 5);
    wr(3'd1, 8'h9A); rd(3'd1, v); check("R2 prediv readback", v, 8'h9A);
    rd(3'd6, v); check("R2 unused address", v, 0);

    // R10 enable off: output low even at full brightness
    wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
    wr(3'd0, 8'h02);
    repeat (100) @(negedge clk);
    begin
      int hc = 0;
      for (int i = 0; i < 200; i++) begin @(negedge clk); if (pwm_out) hc++; end
      check("R10 output low while disabled", hc, 0);
    end

    // R3/R5 F=3 Pn=4 bright 0x8000 -> duty 8, high 24, period 48
    wr(3'd1, 8'd3); wr(3'd2, 8'd4); wr(3'd3, 8'h80); wr(3'd4, 8'h00);
    wr(3'd0, 8'h03);
    expect_pwm("R3 R5 F3 Pn4", 24, 48);
    // R5 low bits discarded
    wr(3'd4, 8'hFF); wr(3'd3, 8'h8F);
    expect_pwm("R5 low bits discarded", 24, 48);
    // R5 Pn=8 F=2 bright 0x40FF -> duty 64, high 128, period 512
    wr(3'd1, 8'd2); wr(3'd2, 8'd8); wr(3'd3, 8'h40);
    expect_pwm("R5 F2 Pn8", 128, 512);
    // R7 zero duty
    wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    expect_pwm("R7 zero duty", 0, 512);
    // R7 all ones in assigned bits (Pn=4, F=2, 0xF000)
    wr(3'd2, 8'd4); wr(3'd3, 8'hF0);
    expect_pwm("R7 full duty", 32, 32);
    // R3 F=0 treated as 1 (Pn=4, bright 0x3000 -> duty 3)
    wr(3'd1, 8'd0); wr(3'd3, 8'h30);
    expect_pwm("R3 F zero as one", 3, 16);
    // R6 narrow mode: hi 0x80, lo 0xFF, Pn=10, F=1 -> duty 512 of 1024
    wide_bright = 1'b0;
    wr(3'd2, 8'd10); wr(3'd3, 8'h80); wr(3'd4, 8'hFF);
    expect_pwm("R6 narrow ignores low byte", 512, 1024);
    wide_bright = 1'b1;
    // R8 frequency-set off -> default F=4 Pn=4, bright 0x8000 -> duty 8
    wr(3'd4, 8'h00); wr(3'd1, 8'd7); wr(3'd2, 8'd6);
    wr(3'd0, 8'h01);
    expect_pwm("R8 default divider", 32, 64);

    // R9 mid-period brightness change waits for the period boundary
    wr(3'd3, 8'h20);  // duty 2 -> high 8 of 64
    expect_pwm("R9 setup", 8, 64);
    begin
      bit prev = 1'b1;
      int late_high = 0;
      @(negedge clk); prev = pwm_out;
      while (!(prev == 1'b0 && pwm_out == 1'b1)) begin prev = pwm_out; @(negedge clk); end
      for (int i = 1; i < 64; i++) begin
        if (i == 20) begin wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'hF0; end
        if (i == 21) wr_en = 1'b0;
        @(negedge clk);
        if (i >= 8 && pwm_out) late_high++;
      end
      check("R9 no change mid-period", late_high, 0);
      @(negedge clk);
      check("R9 new duty at next period", int'(pwm_out), 1);
    end

    // R10 disabling drives the output low
    wr(3'd0, 8'h00);
    @(negedge clk);
    check("R10 low after disable", int'(pwm_out), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule